// File: doc/BRIEF.md
# Configurable PLA Logic Array

This block is a programmable sum-of-products array. A set of configuration registers, the personality matrix, defines each product term by giving one 2-bit literal code per input. It also defines which outputs each term drives. The outputs are evaluated combinationally from the live input vector and the stored matrix, so a change on the inputs appears on the outputs in the same cycle.

Configuration is loaded one term row at a time through a valid/ready write port. A row carries the term index, the literal codes for all inputs, and an output-connection mask. The port holds back (ready low) for exactly one cycle after each accepted row while that row is committed. Until the commit edge, the outputs keep computing from the old matrix.

A build parameter picks one of two OR-plane variants. In array mode the OR plane is programmable, and one term may feed any number of outputs. In fixed-group mode each output is hard-wired to its own private block of terms, and the mask carried by a row is ignored.

Top module: `pla_array`

## Requirements
- R1: Literal code 01 makes a term require its input to be 1, and code 10 makes the term require that input to be 0. The code for input i sits at row bits [2i+1:2i].
- R2: Code 00 removes an input from the term. A term whose codes are all 00 evaluates to 1.
- R3: Code 11 in any input position forces the term to 0, whatever the inputs are.
- R4: In array mode (PAL_MODE=0), bit o of a row's output mask connects that term to output o. Output o is the OR of all connected terms, and a single term may drive several outputs.
- R5: In fixed-group mode (PAL_MODE=1), output o is the OR of terms o*TERMS_PER_OUT through o*TERMS_PER_OUT+TERMS_PER_OUT-1 only. The output mask of a written row has no effect. A slot left at its reset state contributes 0.
- R6: A row is accepted on a rising edge where cfg_valid and cfg_ready are both high. cfg_ready is low during the following cycle and high again after the commit edge.
- R7: After the accepting edge the outputs still follow the previous matrix. The written row takes effect from the next rising edge onward.
- R8: After reset every term holds code 11 in all positions and every mask is clear. All outputs read 0 and cfg_ready is 1.
- R9: With terms AB, BC', AC', B'C' and A, and masks chosen for sharing, the outputs are F0 = A + BC', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C' + A for every input combination. A, B and C are inputs 0, 1 and 2.
- R10: The evaluation path is combinational: outputs reflect a new input vector within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | A configuration row is offered |
| cfg_ready | output | 1 | Port can accept a row this cycle |
| cfg_term | input | TERM_AW | Index of the term row being written |
| cfg_and | input | 2*N_IN | Literal codes, two bits per input |
| cfg_or | input | N_OUT | Output-connection mask for the term (ignored in fixed-group mode) |
| in_vec | input | N_IN | Logic inputs |
| f_out | output | N_OUT | Sum-of-products outputs |

## Verification
Output results depend only on the current inputs, so every evaluation is checked a few nanoseconds after the rising edge that follows the input change. By then the combinational value has settled, and no further edge is involved. The write timing is checked against the clock edges. One nanosecond after the accepting edge the bench checks that ready is low and that the outputs still show the old matrix. One nanosecond after the next edge it checks that ready is back and that the new row is visible. The scoreboard monitor samples once per cycle, five nanoseconds past the edge. The driver therefore queues each expectation in the window before that sample point.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    LIT_SKIP = 2'b00,
    LIT_POS  = 2'b01,
    LIT_NEG  = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;

  function automatic logic lit_pass(input logic [1:0] code, input logic x);
    case (lit_code_e'(code))
      LIT_SKIP: lit_pass = 1'b1;
      LIT_POS:  lit_pass = x;
      LIT_NEG:  lit_pass = ~x;
      default:  lit_pass = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_IN    = 4,
  parameter int N_TERM  = 16,
  parameter int N_OUT   = 4,
  parameter int TERM_AW = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_valid,
  output logic                                wr_ready,
  input  logic [TERM_AW-1:0]                  wr_term,
  input  logic [2*N_IN-1:0]                   wr_and,
  input  logic [N_OUT-1:0]                    wr_or,
  output logic [N_TERM-1:0][2*N_IN-1:0]       and_mem,
  output logic [N_TERM-1:0][N_OUT-1:0]        or_mem
);
  localparam int ROW_W = 2 * N_IN;

  logic               pend_q;
  logic [TERM_AW-1:0] term_q;
  logic [ROW_W-1:0]   and_q;
  logic [N_OUT-1:0]   or_q;
  logic               fire;

  assign wr_ready = ~pend_q;
  assign fire     = wr_valid & wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      term_q  <= '0;
      and_q   <= '0;
      or_q    <= '0;
      and_mem <= '1;
      or_mem  <= '0;
    end else begin
      if (fire) begin
        pend_q <= 1'b1;
        term_q <= wr_term;
        and_q  <= wr_and;
        or_q   <= wr_or;
      end
      if (pend_q) begin
        pend_q <= 1'b0;
        if (int'(term_q) < N_TERM) begin
          and_mem[term_q] <= and_q;
          or_mem[term_q]  <= or_q;
        end
      end
    end
  end

  // R6: the port stalls for the commit cycle after an accept
  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !wr_ready);
  // R6: the stall lasts a single cycle
  assert_ready_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> wr_ready);
  // R7: the accepting edge leaves the live matrix untouched
  assert_hold_matrix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ($stable(and_mem) && $stable(or_mem)));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_TERM-1:0][2*N_IN-1:0] and_mem,
  input  logic [N_IN-1:0]               in_vec,
  output logic [N_TERM-1:0]             term_vec
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic prod;
    logic killed;

    always_comb begin
      prod = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        prod = prod & lit_pass(and_mem[t][2*i +: 2], in_vec[i]);
      end
    end
    assign term_vec[t] = prod;

    always_comb begin
      killed = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        if (and_mem[t][2*i +: 2] == LIT_KILL) killed = 1'b1;
      end
    end

    // R3: a kill code anywhere in the row silences the term
    assert_kill_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
      killed |-> !term_vec[t]);
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM        = 16,
  parameter int N_OUT         = 4,
  parameter int TERMS_PER_OUT = 4,
  parameter bit PAL_MODE      = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_TERM-1:0]            term_vec,
  input  logic [N_TERM-1:0][N_OUT-1:0] or_mem,
  output logic [N_OUT-1:0]             f_out
);
  if (PAL_MODE) begin : g_fixed
    logic unused_mask;
    assign unused_mask = ^or_mem;
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      assign f_out[o] = |term_vec[o*TERMS_PER_OUT +: TERMS_PER_OUT];
    end
  end else begin : g_prog
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic [N_TERM-1:0] col;
      always_comb begin
        for (int t = 0; t < N_TERM; t++) col[t] = or_mem[t][o];
      end
      assign f_out[o] = |(term_vec & col);
    end
  end

  // R4/R5: with no live product term, no output can be high
  assert_no_term_no_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (term_vec == '0) |-> (f_out == '0));
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN          = 4,
  parameter int N_TERM        = 16,
  parameter int N_OUT         = 4,
  parameter int TERMS_PER_OUT = 4,
  parameter bit PAL_MODE      = 1'b0,
  localparam int TERM_AW      = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [TERM_AW-1:0] cfg_term,
  input  logic [2*N_IN-1:0]  cfg_and,
  input  logic [N_OUT-1:0]   cfg_or,
  input  logic [N_IN-1:0]    in_vec,
  output logic [N_OUT-1:0]   f_out
);
  logic [N_TERM-1:0][2*N_IN-1:0] and_mem;
  logic [N_TERM-1:0][N_OUT-1:0]  or_mem;
  logic [N_TERM-1:0]             term_vec;

  pla_cfg_store #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .TERM_AW(TERM_AW)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(cfg_valid), .wr_ready(cfg_ready),
    .wr_term(cfg_term), .wr_and(cfg_and), .wr_or(cfg_or),
    .and_mem(and_mem), .or_mem(or_mem)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk(clk), .rst_n(rst_n),
    .and_mem(and_mem), .in_vec(in_vec), .term_vec(term_vec)
  );

  pla_or_plane #(
    .N_TERM(N_TERM), .N_OUT(N_OUT),
    .TERMS_PER_OUT(TERMS_PER_OUT), .PAL_MODE(PAL_MODE)
  ) u_or (
    .clk(clk), .rst_n(rst_n),
    .term_vec(term_vec), .or_mem(or_mem), .f_out(f_out)
  );

  // R8: leaving reset, all outputs are low and the port is open
  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (f_out == '0 && cfg_ready));
endmodule

// File: tb/pla_array_test.sv
module pla_array_test;
  localparam int NI = 4;
  localparam int NT = 16;
  localparam int NO = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          a_valid = 1'b0, b_valid = 1'b0;
  logic          a_ready, b_ready;
  logic [AW-1:0] w_term = '0;
  logic [2*NI-1:0] w_and = '0;
  logic [NO-1:0] w_or = '0;
  logic [NI-1:0] in_vec = '0;
  logic [NO-1:0] fa, fb;

  pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO), .TERMS_PER_OUT(4), .PAL_MODE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(a_valid), .cfg_ready(a_ready),
    .cfg_term(w_term), .cfg_and(w_and), .cfg_or(w_or), .in_vec(in_vec), .f_out(fa));

  pla_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO), .TERMS_PER_OUT(4), .PAL_MODE(1'b1)) uut_pal (
    .clk(clk), .rst_n(rst_n), .cfg_valid(b_valid), .cfg_ready(b_ready),
    .cfg_term(w_term), .cfg_and(w_and), .cfg_or(w_or), .in_vec(in_vec), .f_out(fb));

  typedef struct {
    bit            pal;
    logic [NO-1:0] exp;
    string         req;
  } item_t;
  item_t sb[$];

  int tests = 0;
  int fails = 0;

  task automatic check(string req, logic [NO-1:0] act, logic [NO-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // monitor: compares queued expectations 5 ns after each rising edge
  initial forever begin
    @(posedge clk);
    #5;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.req, it.pal ? fb : fa, it.exp);
    end
  end

  task automatic push(bit pal, logic [NO-1:0] exp, string req);
    item_t it;
    it.pal = pal; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic expect_f(bit pal, logic [NI-1:0] v, logic [NO-1:0] exp, string req);
    @(negedge clk);
    in_vec = v;
    push(pal, exp, req);
    @(posedge clk);
    #6;
  endtask

  task automatic wr(bit pal, logic [AW-1:0] t, logic [2*NI-1:0] a, logic [NO-1:0] o);
    @(negedge clk);
    w_term = t; w_and = a; w_or = o;
    if (pal) b_valid = 1'b1; else a_valid = 1'b1;
    @(posedge clk);
    #1;
    a_valid = 1'b0; b_valid = 1'b0;
    check("R6 ready low after accept", {3'b0, pal ? b_ready : a_ready}, 4'b0000);
    @(posedge clk);
    #1;
    check("R6 ready back after commit", {3'b0, pal ? b_ready : a_ready}, 4'b0001);
  endtask

  initial begin
    #(200000 * 20);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic a, b, c;
    logic [NO-1:0] e;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 ready after reset", {2'b0, b_ready, a_ready}, 4'b0011);
    expect_f(1'b0, 4'hF, 4'h0, "R8 array outputs cleared");
    expect_f(1'b1, 4'hF, 4'h0, "R8 fixed outputs cleared");
    expect_f(1'b0, 4'h0, 4'h0, "R8 array outputs cleared, zero inputs");

    // R2: all-skip term is constant 1
    wr(1'b0, 4'd0, 8'h00, 4'b0001);
    expect_f(1'b0, 4'h0, 4'b0001, "R2 all-skip term, inputs 0");
    expect_f(1'b0, 4'hA, 4'b0001, "R2 all-skip term, inputs A");

    // R3: kill code on input 1 silences the term even with A true
    wr(1'b0, 4'd0, 8'h0D, 4'b0001);
    expect_f(1'b0, 4'h1, 4'b0000, "R3 kill code");
    expect_f(1'b0, 4'hF, 4'b0000, "R3 kill code, all ones");

    // R1: A true, B complemented -> F0 = A & ~B
    wr(1'b0, 4'd0, 8'h09, 4'b0001);
    for (int v = 0; v < 4; v++) begin
      e = {3'b000, v[0] & ~v[1]};
      expect_f(1'b0, 4'(v), e, "R1 true/complement literals");
    end

    // R9/R4: shared-term configuration
    wr(1'b0, 4'd0, 8'h05, 4'b0110);  // AB   -> F1, F2
    wr(1'b0, 4'd1, 8'h24, 4'b0001);  // BC'  -> F0
    wr(1'b0, 4'd2, 8'h21, 4'b0010);  // AC'  -> F1
    wr(1'b0, 4'd3, 8'h28, 4'b1100);  // B'C' -> F2, F3
    wr(1'b0, 4'd4, 8'h01, 4'b1001);  // A    -> F0, F3
    for (int v = 0; v < 16; v++) begin
      a = v[0]; b = v[1]; c = v[2];
      e[0] = a | (b & ~c);
      e[1] = (a & ~c) | (a & b);
      e[2] = (~b & ~c) | (a & b);
      e[3] = (~b & ~c) | a;
      expect_f(1'b0, 4'(v), e, "R9 shared-term equations");
    end
    // R4: term AB alone drives both F1 and F2 (A=1,B=1,C=1)
    expect_f(1'b0, 4'b0111, 4'b1111, "R4 one term on two outputs");
    // R10: new input seen in the same cycle
    expect_f(1'b0, 4'b0010, 4'b0001, "R10 combinational follow");

    // R7: kill term A while A=1,B=0,C=0
    @(negedge clk);
    in_vec = 4'b0001;
    w_term = 4'd4; w_and = 8'hC0; w_or = 4'b1001;
    a_valid = 1'b1;
    @(posedge clk);
    #1;
    a_valid = 1'b0;
    push(1'b0, 4'b1111, "R7 old matrix held after accept");
    #6;
    @(posedge clk);
    #1;
    push(1'b0, 4'b1110, "R7 new row after commit");
    #6;

    // R5: fixed groups, mask ignored
    wr(1'b1, 4'd0, 8'h01, 4'b1110);  // group 0: A
    wr(1'b1, 4'd4, 8'h04, 4'b0001);  // group 1: B
    expect_f(1'b1, 4'b0001, 4'b0001, "R5 group 0 only, mask ignored");
    expect_f(1'b1, 4'b0010, 4'b0010, "R5 group 1 only");
    expect_f(1'b1, 4'b0011, 4'b0011, "R5 both groups");
    wr(1'b1, 4'd5, 8'h20, 4'b1111);  // group 1: C'
    expect_f(1'b1, 4'b0000, 4'b0010, "R5 second term in group 1");
    expect_f(1'b1, 4'b0101, 4'b0001, "R5 untouched slots stay 0");

    repeat (2) @(posedge clk);
    #6;
    finish_run();
  end
endmodule